// File: doc/BRIEF.md
# Codec Power Mode Controller

This block sets the power state of a line-interface codec. Software writes a mode register that holds two control bits: a power-down bit and a link-off bit. It also writes three clock-configuration registers. From the current mode the controller drives three enables: one for the isolation-link transceiver, one for the core datapath and one for the ring-detect path. A request for normal operation or for sleep goes through only if the clock configuration is valid. A request that fails this check leaves the mode unchanged and raises a sticky error flag.

Once the block is asleep it ignores every register write. It leaves sleep only when the external active-low reset pin is pulled low. The pin is brought into the clock domain by a two-stage synchronizer and must stay low for a minimum number of cycles before it counts as a reset. A taken reset puts the block back in reset mode and clears the clock configuration, so software must program it again. A separate power-on reset input brings the block up in the same state.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After power-on reset the mode is reset mode. The mode register (address 6) reads 0x10: link-off bit 4 set, power-down bit 3 clear. Registers 7, 8 and 9 read zero and the error flag is low.
- R2: A write to address 6 selects the mode from {bit 4, bit 3}: 00 normal, 01 sleep, 10 reset, 11 full power-down. The new mode holds from the clock edge that takes the write. Reading address 6 returns the current mode in those two bits, with all other bits zero.
- R3: A request for normal mode is refused unless registers 7, 8 and 9 all hold non-zero values. When refused, the previous mode stays.
- R4: A request for sleep mode is refused unless registers 7, 8 and 9 all hold non-zero values. When refused, the previous mode stays.
- R5: The enables {link_en, core_en, ring_en} are 111 in normal mode, 011 in reset mode, 101 in sleep and 000 in full power-down.
- R6: While in sleep, writes to address 6 have no effect. Only a pin reset leaves sleep.
- R7: A refused request sets cfg_err. The flag stays set until the next reset.
- R8: Writes to registers 7 to 9 are stored and read back in every mode except sleep. In sleep they are ignored.
- R9: The reset pin passes through a two-flop synchronizer. A reset is taken only after the synchronized level has been low for MIN_LOW consecutive cycles, so a one-cycle low pulse is ignored.
- R10: A taken pin reset returns the block to reset mode, clears registers 7 to 9 and clears cfg_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | External reset / wake pin, active low, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for rd_addr |
| link_en | output | 1 | Isolation-link transceiver enable |
| core_en | output | 1 | Core datapath enable |
| ring_en | output | 1 | Ring-detect path enable |
| cfg_err | output | 1 | Sticky flag for a refused mode request |

## Verification
The bench uses the default parameters: an 8-bit data path, the mode register at address 6 with its bits at positions 4 and 3, three configuration registers at addresses 7 to 9, and MIN_LOW of 2. With MIN_LOW at 2, both sides of the pin filter's threshold can be tested in a few cycles: a one-cycle low pulse must be rejected and a longer low must be taken. The mode table walks through refused and accepted requests and through writes while asleep. After the pin reset, the configuration registers are read back to confirm they were cleared.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
    // Mode code is {link-off bit, power-down bit} of the mode register
    typedef enum logic [1:0] {
        M_NORMAL = 2'b00,
        M_SLEEP  = 2'b01,
        M_RESET  = 2'b10,
        M_OFF    = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  err;
    } mode_st_t;
endpackage

// File: rtl/cpm_pin_filter.sv
module cpm_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic rst_req
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_n};
        if (st_q.sync[SYNC_STAGES-1]) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.sync <= '1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req = (st_q.cnt == CNT_MAX);

    // A reset request only exists after the synchronized pin was low
    AST_REQ_NEEDS_LOW: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> !$past(st_q.sync[SYNC_STAGES-1])); // R9
endmodule

// File: rtl/cpm_cfg_regs.sv
module cpm_cfg_regs #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int CFG_BASE = 7,
    parameter int CFG_NUM  = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_req,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_val,
    output logic              cfg_ok
);
    logic [CFG_NUM-1:0][DATA_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d  = cfg_q;
        cfg_ok = 1'b1;
        rd_hit = 1'b0;
        rd_val = '0;
        for (int i = 0; i < CFG_NUM; i++) begin
            if (wr_en && !lock && wr_addr == ADDR_W'(CFG_BASE + i)) begin
                cfg_d[i] = wr_data;
            end
            if (cfg_q[i] == '0) begin
                cfg_ok = 1'b0;
            end
            if (rd_addr == ADDR_W'(CFG_BASE + i)) begin
                rd_hit = 1'b1;
                rd_val = cfg_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= '0;
        end else if (rst_req) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!por_n || rst_req)
        lock |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/cpm_mode_fsm.sv
module cpm_mode_fsm
    import cpm_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int PDN_BIT = 3,
    parameter int PDL_BIT = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_req,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_ok,
    output mode_e             mode,
    output logic              err
);
    mode_st_t st_d, st_q;
    mode_e    req;

    always_comb begin
        st_d = st_q;
        req  = mode_e'({wr_data[PDL_BIT], wr_data[PDN_BIT]});
        if (mode_wr && st_q.mode != M_SLEEP) begin
            if ((req == M_NORMAL || req == M_SLEEP) && !cfg_ok) begin
                st_d.err = 1'b1;
            end else begin
                st_d.mode = req;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.mode <= M_RESET;
            st_q.err  <= 1'b0;
        end else if (rst_req) begin
            st_q.mode <= M_RESET;
            st_q.err  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign err  = st_q.err;

    AST_NORMAL_GATED: assert property (@(posedge clk) disable iff (!por_n || rst_req)
        (st_q.mode != M_NORMAL && !cfg_ok) |=> (st_q.mode != M_NORMAL)); // R3
    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!por_n || rst_req)
        (st_q.mode != M_SLEEP && !cfg_ok) |=> (st_q.mode != M_SLEEP)); // R4
    AST_SLEEP_HELD: assert property (@(posedge clk) disable iff (!por_n || rst_req)
        (st_q.mode == M_SLEEP) |=> (st_q.mode == M_SLEEP)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n || rst_req)
        st_q.err |=> st_q.err); // R7
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
    import cpm_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int MODE_ADDR   = 6,
    parameter int CFG_BASE    = 7,
    parameter int CFG_NUM     = 3,
    parameter int PDN_BIT     = 3,
    parameter int PDL_BIT     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              link_en,
    output logic              core_en,
    output logic              ring_en,
    output logic              cfg_err
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);

    logic              rst_req;
    logic              cfg_ok;
    logic              rd_hit;
    logic [DATA_W-1:0] rd_val;
    mode_e             mode;

    cpm_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_filt (
        .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .rst_req(rst_req)
    );

    cpm_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_BASE(CFG_BASE),
                   .CFG_NUM(CFG_NUM)) u_regs (
        .clk(clk), .por_n(por_n), .rst_req(rst_req),
        .lock(mode == M_SLEEP), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_hit(rd_hit),
        .rd_val(rd_val), .cfg_ok(cfg_ok)
    );

    cpm_mode_fsm #(.DATA_W(DATA_W), .PDN_BIT(PDN_BIT), .PDL_BIT(PDL_BIT)) u_fsm (
        .clk(clk), .por_n(por_n), .rst_req(rst_req),
        .mode_wr(wr_en && wr_addr == MODE_A), .wr_data(wr_data),
        .cfg_ok(cfg_ok), .mode(mode), .err(cfg_err)
    );

    always_comb begin
        link_en = (mode == M_NORMAL) || (mode == M_SLEEP);
        core_en = (mode == M_NORMAL) || (mode == M_RESET);
        ring_en = (mode != M_OFF);
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == MODE_A) begin
            rd_data[PDL_BIT] = mode[1];
            rd_data[PDN_BIT] = mode[0];
        end else if (rd_hit) begin
            rd_data = rd_val;
        end
    end

    AST_LINK_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        $past(rst_req) |-> (!link_en && core_en)); // R10
    AST_CORE_IMPLIES_RING: assert property (@(posedge clk) disable iff (!por_n)
        core_en |-> ring_en); // R5
endmodule

// File: tb/tb_codec_pwr_ctrl.sv
module tb_codec_pwr_ctrl;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       link_en, core_en, ring_en, cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    codec_pwr_ctrl dut (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .link_en(link_en), .core_en(core_en),
        .ring_en(ring_en), .cfg_err(cfg_err)
    );

    // {addr, data, expected reg6 readback, expected {link,core,ring}, expected err}
    localparam int NV = 11;
    localparam logic [23:0] VEC [NV] = '{
        {4'd6, 8'h00, 8'h10, 3'b011, 1'b1},  // R3 refused normal, no cfg
        {4'd7, 8'h01, 8'h10, 3'b011, 1'b1},  // R8
        {4'd8, 8'h02, 8'h10, 3'b011, 1'b1},  // R8
        {4'd6, 8'h08, 8'h10, 3'b011, 1'b1},  // R4 refused sleep, reg9 zero
        {4'd9, 8'h03, 8'h10, 3'b011, 1'b1},  // R8
        {4'd6, 8'h00, 8'h00, 3'b111, 1'b1},  // R2 normal accepted
        {4'd6, 8'h18, 8'h18, 3'b000, 1'b1},  // R5 full power-down
        {4'd6, 8'h10, 8'h10, 3'b011, 1'b1},  // R2 back to reset mode
        {4'd6, 8'h08, 8'h08, 3'b101, 1'b1},  // R5 sleep
        {4'd6, 8'h00, 8'h08, 3'b101, 1'b1},  // R6 write ignored in sleep
        {4'd7, 8'h00, 8'h08, 3'b101, 1'b1}   // R8 cfg write ignored in sleep
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic write_reg(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(string req, logic [3:0] a, logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    initial begin
        #(CLK_P * 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 enables", {29'd0, link_en, core_en, ring_en}, 32'b011);
        check("R1 err", {31'd0, cfg_err}, 32'd0);
        read_chk("R1 reg6", 4'd6, 8'h10);
        read_chk("R1 reg7", 4'd7, 8'h00);
        read_chk("R1 reg9", 4'd9, 8'h00);

        for (int i = 0; i < NV; i++) begin
            write_reg(VEC[i][23:20], VEC[i][19:12]);
            check($sformatf("R5 vec%0d enables", i),
                  {29'd0, link_en, core_en, ring_en}, {29'd0, VEC[i][3:1]});
            check($sformatf("R7 vec%0d err", i), {31'd0, cfg_err}, {31'd0, VEC[i][0]});
            read_chk($sformatf("R2 vec%0d reg6", i), 4'd6, VEC[i][11:4]);
        end

        read_chk("R8 reg7 kept in sleep", 4'd7, 8'h01);
        read_chk("R8 reg8", 4'd8, 8'h02);
        read_chk("R8 reg9", 4'd9, 8'h03);

        // R9 one-cycle low pulse is ignored
        @(negedge clk); rst_pin_n = 1'b0;
        @(negedge clk); rst_pin_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 short pulse ignored", {29'd0, link_en, core_en, ring_en}, 32'b101);
        read_chk("R9 reg6 still sleep", 4'd6, 8'h08);

        // R10 long pulse wakes to reset mode and clears state
        @(negedge clk); rst_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 enables", {29'd0, link_en, core_en, ring_en}, 32'b011);
        check("R10 err cleared", {31'd0, cfg_err}, 32'd0);
        read_chk("R10 reg6", 4'd6, 8'h10);
        read_chk("R10 reg7 cleared", 4'd7, 8'h00);
        read_chk("R10 reg8 cleared", 4'd8, 8'h00);

        // R8 writes accepted again after wake
        write_reg(4'd8, 8'h5A);
        read_chk("R8 write after wake", 4'd8, 8'h5A);

        finish_run();
    end
endmodule